// File: doc/BRIEF.md
# Narrowing float-to-integer element converter

This block turns a stream of binary32 floating-point elements into 16-bit integers, signed or unsigned, one element per valid beat. Each source element is twice the width of its result. A two-bit operation code picks the signedness of the result. It also picks whether rounding follows a 3-bit dynamic rounding-mode input or is forced to round-toward-zero whatever that input holds. A per-element mask bit decides whether the element is converted or whether the previous destination value, supplied with the element, is handed back unchanged.

Every converted element may raise exception flags. These are ORed into a 5-bit sticky register that keeps its bits until a clear input is pulsed. Results leave the block exactly two clock edges after the element is presented. The pipeline never stalls, so a new element may be accepted on every cycle. A dynamic-mode element carrying a reserved rounding code is not converted. It is marked illegal on its output beat instead.

Top module: `narrow_f2i_cvt`

## Requirements
- R1: An element presented with `in_valid_i` high before clock edge k appears with `out_valid_o` high after edge k+1. `out_valid_o` is low in every other cycle. One element is accepted per cycle with no stall.
- R2: `op_i[0]` selects the result type (1 signed, 0 unsigned). `op_i[1]`=1 forces round-toward-zero and ignores `frm_i` entirely, including its reserved codes.
- R3: With `op_i[1]`=0, rounding follows `frm_i`: 000 to nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 to nearest with ties away from zero.
- R4: A result inside the range (0..65535 unsigned, -32768..32767 signed) is the rounded value, as two's complement when signed. NX (flag bit 0) is raised exactly when rounding changed the value.
- R5: Any NaN input returns 0xFFFF (unsigned) or 0x7FFF (signed), whatever its sign bit, and raises only NV (flag bit 4).
- R6: A rounded value above the range maximum, including +infinity, returns the maximum. A rounded value below the minimum, including -infinity, returns 0x0000 (unsigned) or 0x8000 (signed). Both cases raise only NV.
- R7: In unsigned mode, a negative input whose rounded value is zero returns 0 and raises only NX, never NV.
- R8: When `mask_i` is 0, `dst_o` equals the `old_dst_i` given with that element, and the sticky flags are unchanged.
- R9: `fflags_o` bits are {NV[4], DZ[3], OF[2], UF[1], NX[0]}. They accumulate by OR over converted elements and only `flag_clr_i` clears them. A clear drops the prior contents, and the flags of an element leaving in the same cycle are still kept. DZ, OF and UF stay 0.
- R10: With `op_i[1]`=0 and `frm_i` in 101..111, the output beat has `illegal_o`=1 and `dst_o`=`old_dst_i`, and the flags are unchanged. This holds whatever `mask_i` is. `illegal_o` is 0 on every other beat.
- R11: While `rst_ni` is low, `out_valid_o` and `fflags_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Element present this cycle |
| op_i | input | 2 | Bit 0 signed result, bit 1 forced round-toward-zero |
| frm_i | input | 3 | Dynamic rounding mode |
| mask_i | input | 1 | 1 converts the element, 0 keeps the old value |
| src_i | input | 32 | binary32 source element |
| old_dst_i | input | 16 | Previous destination element |
| flag_clr_i | input | 1 | Clears the sticky flags |
| out_valid_o | output | 1 | Result beat |
| dst_o | output | 16 | Result element |
| illegal_o | output | 1 | Reserved rounding code on this beat |
| fflags_o | output | 5 | Sticky exception flags |

## Verification
Several sources are swept under every operation code and every rounding code. They cover both signs, every exponent from far below one to well beyond the 16-bit range, and mantissas with empty, half-way, just-above-half and full fractions. Together these separate the five rounding directions, the tie rules, and the signed and unsigned saturation edges. Zeros, subnormals, infinities and quiet and signalling NaNs of both signs exercise the saturation and flag rules. Hand-picked values sit half a unit on either side of 65535, 32767 and -32768 to expose off-by-one range checks. The mask pattern interleaves kept and converted elements back to back, so a pass-through value that leaks into the flags or into a neighbouring beat is caught. A negative fraction in unsigned mode after a flag clear tells NX-only apart from NV.

// File: rtl/narrow_f2i_pkg.sv
package narrow_f2i_pkg;
  parameter int DST_W  = 16;
  parameter int SRC_W  = 2 * DST_W;
  parameter int EXP_W  = 8;
  parameter int MAN_W  = SRC_W - EXP_W - 1;
  parameter int SIG_W  = MAN_W + 1;
  parameter int RND_W  = SIG_W + 2;
  parameter int BIAS   = (1 << (EXP_W - 1)) - 1;
  parameter int EXP_MAX = (1 << EXP_W) - 1;
  parameter int BIG_EXP = BIAS + DST_W + 1;
  parameter int SH_W   = EXP_W + 2;
  parameter int FLAG_W = 5;
  parameter int FL_NV  = 4;
  parameter int FL_NX  = 0;
  parameter int OP_SGN = 0;
  parameter int OP_RTZ = 1;

  typedef enum logic [2:0] {
    RM_RNE = 3'd0,
    RM_RTZ = 3'd1,
    RM_RDN = 3'd2,
    RM_RUP = 3'd3,
    RM_RMM = 3'd4
  } rm_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             big;
    logic [SIG_W-1:0] ipart;
    logic             grd;
    logic             stk;
  } unpk_t;
endpackage

// File: rtl/nf2i_unpack.sv
module nf2i_unpack
  import narrow_f2i_pkg::*;
(
  input  logic [SRC_W-1:0] src_i,
  output unpk_t            unpk_o
);
  logic [EXP_W-1:0]       ex;
  logic [MAN_W-1:0]       mn;
  logic [SIG_W-1:0]       sig;
  logic [SH_W-1:0]        sh;
  logic [SIG_W+RND_W-1:0] wide;

  always_comb begin
    ex  = src_i[SRC_W-2 -: EXP_W];
    mn  = src_i[MAN_W-1:0];
    sig = {(ex != '0), mn};
    // subnormals share the exponent of the smallest normal
    sh  = (ex == '0) ? SH_W'(BIAS + MAN_W - 1) : SH_W'(BIAS + MAN_W) - SH_W'(ex);
    wide = '0;
    unpk_o.sign  = src_i[SRC_W-1];
    unpk_o.nan   = (ex == EXP_W'(EXP_MAX)) && (mn != '0);
    unpk_o.big   = (ex >= EXP_W'(BIG_EXP));
    unpk_o.ipart = '0;
    unpk_o.grd   = 1'b0;
    unpk_o.stk   = 1'b0;
    if (!unpk_o.big) begin
      if (sh >= SH_W'(RND_W)) begin
        unpk_o.stk = |sig;
      end else begin
        wide = {sig, RND_W'(0)} >> sh;
        unpk_o.ipart = wide[RND_W +: SIG_W];
        unpk_o.grd   = wide[RND_W-1];
        unpk_o.stk   = |wide[RND_W-2:0];
      end
    end
  end
endmodule

// File: rtl/nf2i_round.sv
module nf2i_round
  import narrow_f2i_pkg::*;
(
  input  unpk_t            unpk_i,
  input  logic             sgn_i,
  input  rm_e              rm_i,
  output logic [DST_W-1:0] res_o,
  output logic             nv_o,
  output logic             nx_o
);
  localparam int MAG_W = SIG_W + 1;
  localparam logic [MAG_W-1:0] UMAX     = MAG_W'((1 << DST_W) - 1);
  localparam logic [MAG_W-1:0] SMAX     = MAG_W'((1 << (DST_W - 1)) - 1);
  localparam logic [MAG_W-1:0] SMIN_MAG = MAG_W'(1 << (DST_W - 1));
  localparam logic [DST_W-1:0] R_UMAX   = '1;
  localparam logic [DST_W-1:0] R_SMAX   = {1'b0, {(DST_W-1){1'b1}}};
  localparam logic [DST_W-1:0] R_SMIN   = {1'b1, {(DST_W-1){1'b0}}};

  logic             inexact, inc;
  logic [MAG_W-1:0] mag;

  always_comb begin
    inexact = unpk_i.grd | unpk_i.stk;
    unique case (rm_i)
      RM_RNE:  inc = unpk_i.grd & (unpk_i.stk | unpk_i.ipart[0]);
      RM_RTZ:  inc = 1'b0;
      RM_RDN:  inc = unpk_i.sign & inexact;
      RM_RUP:  inc = ~unpk_i.sign & inexact;
      RM_RMM:  inc = unpk_i.grd;
      default: inc = 1'b0;
    endcase
    mag   = {1'b0, unpk_i.ipart} + MAG_W'(inc);
    res_o = '0;
    nv_o  = 1'b0;
    nx_o  = 1'b0;
    if (unpk_i.nan) begin
      nv_o  = 1'b1;
      res_o = sgn_i ? R_SMAX : R_UMAX;
    end else if (unpk_i.big) begin
      nv_o  = 1'b1;
      if (unpk_i.sign) res_o = sgn_i ? R_SMIN : '0;
      else             res_o = sgn_i ? R_SMAX : R_UMAX;
    end else if (sgn_i) begin
      if (!unpk_i.sign && mag > SMAX) begin
        nv_o = 1'b1; res_o = R_SMAX;
      end else if (unpk_i.sign && mag > SMIN_MAG) begin
        nv_o = 1'b1; res_o = R_SMIN;
      end else begin
        res_o = unpk_i.sign ? (~mag[DST_W-1:0] + 1'b1) : mag[DST_W-1:0];
        nx_o  = inexact;
      end
    end else begin
      if (unpk_i.sign && mag != '0) begin
        nv_o = 1'b1; res_o = '0;
      end else if (mag > UMAX) begin
        nv_o = 1'b1; res_o = R_UMAX;
      end else begin
        res_o = mag[DST_W-1:0];
        nx_o  = inexact;
      end
    end
  end
endmodule

// File: rtl/nf2i_flags.sv
module nf2i_flags
  import narrow_f2i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic [FLAG_W-1:0] new_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (clr_i ? '0 : flags_o) | (acc_i ? new_i : '0);
  end
endmodule

// File: rtl/narrow_f2i_cvt.sv
module narrow_f2i_cvt
  import narrow_f2i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        op_i,
  input  logic [2:0]        frm_i,
  input  logic              mask_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DST_W-1:0]  old_dst_i,
  input  logic              flag_clr_i,
  output logic              out_valid_o,
  output logic [DST_W-1:0]  dst_o,
  output logic              illegal_o,
  output logic [FLAG_W-1:0] fflags_o
);
  unpk_t             unpk_d, s1_unpk;
  logic              s1_valid, s1_mask, s1_ill, s1_sgn;
  rm_e               s1_rm;
  logic [DST_W-1:0]  s1_old;
  logic [DST_W-1:0]  cvt_res;
  logic              cvt_nv, cvt_nx, act;
  logic [FLAG_W-1:0] cvt_flags;
  logic              in_ill;

  nf2i_unpack u_unpack (.src_i(src_i), .unpk_o(unpk_d));

  assign in_ill = !op_i[OP_RTZ] && (frm_i > 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_mask  <= 1'b0;
      s1_ill   <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_rm    <= RM_RNE;
      s1_old   <= '0;
      s1_unpk  <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_mask <= mask_i;
        s1_ill  <= in_ill;
        s1_sgn  <= op_i[OP_SGN];
        s1_rm   <= op_i[OP_RTZ] ? RM_RTZ : rm_e'(frm_i);
        s1_old  <= old_dst_i;
        s1_unpk <= unpk_d;
      end
    end
  end

  nf2i_round u_round (
    .unpk_i(s1_unpk), .sgn_i(s1_sgn), .rm_i(s1_rm),
    .res_o(cvt_res), .nv_o(cvt_nv), .nx_o(cvt_nx)
  );

  assign act = s1_valid && s1_mask && !s1_ill;

  always_comb begin
    cvt_flags        = '0;
    cvt_flags[FL_NV] = cvt_nv;
    cvt_flags[FL_NX] = cvt_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dst_o       <= '0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        dst_o     <= act ? cvt_res : s1_old;
        illegal_o <= s1_ill;
      end
    end
  end

  nf2i_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flag_clr_i),
    .acc_i(act), .new_i(cvt_flags), .flags_o(fflags_o)
  );
endmodule

// File: rtl/nf2i_chk.sv
module nf2i_chk
  import narrow_f2i_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [1:0]        op_i,
  input logic [2:0]        frm_i,
  input logic              mask_i,
  input logic [DST_W-1:0]  old_dst_i,
  input logic              flag_clr_i,
  input logic              out_valid_o,
  input logic [DST_W-1:0]  dst_o,
  input logic              illegal_o,
  input logic [FLAG_W-1:0] fflags_o
);
  logic             v_d1, v_d2, m_d1, m_d2, i_d1, i_d2;
  logic [DST_W-1:0] o_d1, o_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_d1 <= 1'b0; v_d2 <= 1'b0; m_d1 <= 1'b0; m_d2 <= 1'b0;
      i_d1 <= 1'b0; i_d2 <= 1'b0; o_d1 <= '0;   o_d2 <= '0;
    end else begin
      v_d1 <= in_valid_i;
      m_d1 <= mask_i;
      i_d1 <= !op_i[OP_RTZ] && (frm_i > 3'd4);
      o_d1 <= old_dst_i;
      v_d2 <= v_d1; m_d2 <= m_d1; i_d2 <= i_d1; o_d2 <= o_d1;
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == v_d2); // R1
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !m_d2) |-> dst_o == o_d2); // R8
  AST_ILLEGAL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && illegal_o) |-> dst_o == o_d2); // R10
  AST_ILLEGAL_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> illegal_o == i_d2); // R10
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_clr_i |=> (fflags_o & $past(fflags_o)) == $past(fflags_o)); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fflags_o[3:1] == 3'b000); // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(v_d1 && m_d1 && !i_d1) && !flag_clr_i) |=> $stable(fflags_o)); // R8
endmodule

bind narrow_f2i_cvt nf2i_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .op_i(op_i),
  .frm_i(frm_i), .mask_i(mask_i), .old_dst_i(old_dst_i),
  .flag_clr_i(flag_clr_i), .out_valid_o(out_valid_o), .dst_o(dst_o),
  .illegal_o(illegal_o), .fflags_o(fflags_o)
);

// File: tb/narrow_f2i_cvt_bench.sv
module narrow_f2i_cvt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, mask = 1'b0, flag_clr = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  frm = '0;
  logic [31:0] src = '0;
  logic [15:0] old_dst = '0;
  logic        out_valid, illegal;
  logic [15:0] dst;
  logic [4:0]  fflags;

  int n_chk = 0, n_fail = 0, cnt = 0;
  bit done = 0;
  logic [21:0] exp_q[$];
  string       tag_q[$];
  logic [4:0]  exp_flags = '0;

  narrow_f2i_cvt u_narrow_f2i_cvt (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op), .frm_i(frm),
    .mask_i(mask), .src_i(src), .old_dst_i(old_dst), .flag_clr_i(flag_clr),
    .out_valid_o(out_valid), .dst_o(dst), .illegal_o(illegal), .fflags_o(fflags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic real pow2(int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else        repeat (-k) r = r * 0.5;
    return r;
  endfunction

  function automatic real f2r(logic [31:0] b);
    real mag;
    if (b[30:23] == 8'd0) mag = real'(b[22:0]) * pow2(-149);
    else mag = (real'(b[22:0]) + 8388608.0) * pow2(int'(b[30:23]) - 150);
    return b[31] ? -mag : mag;
  endfunction

  function automatic real rnd(real x, logic [2:0] rm);
    real f, d;
    if (x >= 16777216.0 || x <= -16777216.0) return x;
    case (rm)
      3'd1: return (x >= 0.0) ? $floor(x) : -$floor(-x);
      3'd2: return $floor(x);
      3'd3: return $ceil(x);
      3'd4: return (x >= 0.0) ? $floor(x + 0.5) : -$floor(-x + 0.5);
      default: begin
        f = $floor(x); d = x - f;
        if (d > 0.5) return f + 1.0;
        if (d < 0.5) return f;
        return ($rtoi(f) % 2 == 0) ? f : f + 1.0;
      end
    endcase
  endfunction

  // expected {illegal, dst, flags}; flag bits NV=4, NX=0
  function automatic logic [21:0] model(input logic [1:0] o, input logic [2:0] fr,
      input logic mk, input logic [31:0] s, input logic [15:0] od, output string tag);
    logic [2:0] rm; logic [15:0] d; logic [4:0] f; real x, r;
    f = '0; d = '0;
    if (!o[1] && fr > 3'd4) begin tag = "R10"; return {1'b1, od, 5'd0}; end
    if (!mk) begin tag = "R8"; return {1'b0, od, 5'd0}; end
    if (s[30:23] == 8'hFF && s[22:0] != 0) begin
      tag = "R5"; return {1'b0, o[0] ? 16'h7FFF : 16'hFFFF, 5'b10000};
    end
    rm = o[1] ? 3'd1 : fr;
    x = (s[30:23] == 8'hFF) ? (s[31] ? -1.0e40 : 1.0e40) : f2r(s);
    r = rnd(x, rm);
    if (o[0]) begin
      if (r > 32767.0)       begin d = 16'h7FFF; f = 5'b10000; tag = "R6"; end
      else if (r < -32768.0) begin d = 16'h8000; f = 5'b10000; tag = "R6"; end
    end else begin
      if (r > 65535.0)       begin d = 16'hFFFF; f = 5'b10000; tag = "R6"; end
      else if (r < 0.0)      begin d = 16'h0000; f = 5'b10000; tag = "R6"; end
    end
    if (f == 5'd0) begin
      d = 16'($rtoi(r));
      f = (r != x) ? 5'b00001 : 5'b00000;
      if (r == x) tag = "R4";
      else        tag = o[1] ? "R2" : "R3";
      if (!o[0] && x < 0.0 && r == 0.0) tag = "R7";
    end
    return {1'b0, d, f};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R1", "unexpected beat", {15'd0, illegal, dst}, 32'd0);
      end else begin
        logic [21:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        exp_flags = exp_flags | e[4:0];
        check({illegal, dst} == e[21:5] && fflags == exp_flags, t,
              "{illegal,dst,flags}", {10'd0, illegal, dst, fflags},
              {10'd0, e[21:5], exp_flags});
      end
    end
  end

  task automatic push(logic [1:0] o, logic [2:0] fr, logic mk, logic [31:0] s, logic [15:0] od);
    string t; logic [21:0] e;
    e = model(o, fr, mk, s, od, t);
    exp_q.push_back(e); tag_q.push_back(t);
    in_valid = 1'b1; op = o; frm = fr; mask = mk; src = s; old_dst = od;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [22:0] mant_pat(int i);
    case (i)
      0: return 23'h000000; 1: return 23'h000001; 2: return 23'h400000;
      3: return 23'h200000; 4: return 23'h600000; 5: return 23'h7FFFFF;
      6: return 23'h0FFFFF; default: return 23'h2AAAAA;
    endcase
  endfunction

  function automatic logic [31:0] special(int i);
    case (i)
      0: return 32'h00000000;  1: return 32'h80000000;  2: return 32'h00000001;
      3: return 32'h807FFFFF;  4: return 32'h7F800000;  5: return 32'hFF800000;
      6: return 32'h7FC00000;  7: return 32'hFFC00000;  8: return 32'h7F800001;
      9: return 32'h477FFF80; 10: return 32'h47800000; 11: return 32'h46FFFF00;
      12: return 32'hC7000000; 13: return 32'hC7000080; 14: return 32'hC7000100;
      15: return 32'hBE99999A; 16: return 32'h3F000000; 17: return 32'h40200000;
      18: return 32'h477FFF00; 19: return 32'h46FFFE00; 20: return 32'hBF333333;
      default: return 32'h3FC00000;
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && fflags == 5'd0, "R11", "reset state",
          {26'd0, out_valid, fflags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: single element, visible after the second edge only
    push(2'b11, 3'd0, 1'b1, 32'h40200000, 16'h1234);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid after one edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1", "out_valid after two edges", {31'd0, out_valid}, 32'd1);
    idle(3);
    // directed boundaries, all ops and rounding codes (R5 R6 R7 R10)
    for (int i = 0; i < 22; i++)
      for (int o = 0; o < 4; o++)
        for (int fr = 0; fr < 8; fr++)
          push(o[1:0], fr[2:0], 1'b1, special(i), 16'hA5A5);
    idle(3);
    // sweep of sign, exponent and mantissa shapes with interleaved masking (R8)
    for (int sg = 0; sg < 2; sg++)
      for (int e = 100; e <= 160; e++)
        for (int mi = 0; mi < 8; mi++)
          for (int o = 0; o < 4; o++)
            for (int fr = 0; fr < 8; fr++) begin
              cnt++;
              push(o[1:0], fr[2:0], (cnt % 5) != 0, {sg[0], e[7:0], mant_pat(mi)},
                   16'(cnt * 40503));
            end
    idle(4);
    check(fflags[4] && fflags[0], "R9", "flags gathered before clear",
          {27'd0, fflags}, 32'h11);
    flag_clr = 1'b1; exp_flags = '0;
    @(negedge clk);
    flag_clr = 1'b0;
    check(fflags == 5'd0, "R9", "flags after clear", {27'd0, fflags}, 32'd0);
    // R7: unsigned RTZ of -0.3 gives 0 with NX only
    push(2'b10, 3'd6, 1'b1, 32'hBE99999A, 16'h7777);
    idle(3);
    check(fflags == 5'b00001, "R7", "NX only after -0.3 unsigned", {27'd0, fflags}, 32'h1);
    // R8: masked NaN leaves flags alone
    push(2'b01, 3'd0, 1'b0, 32'h7FC00000, 16'h4321);
    idle(3);
    check(fflags == 5'b00001, "R8", "flags after masked NaN", {27'd0, fflags}, 32'h1);
    // R10: reserved code, mask on, leaves flags alone
    push(2'b00, 3'd7, 1'b1, 32'h7F800000, 16'h0F0F);
    idle(3);
    check(fflags == 5'b00001, "R10", "flags after illegal element", {27'd0, fflags}, 32'h1);
    check(exp_q.size() == 0, "R1", "all results delivered", exp_q.size(), 32'd0);
    report();
  end
endmodule